// File: doc/BRIEF.md
# Byte DMA Channel Pair

This block is a direct memory access engine holding two identical channels. Each channel owns a source pointer, a destination pointer and a 16-bit transfer count. Each pointer selects memory space or I/O space on its own and can step up, step down or stay put after every byte. A byte always crosses the bus in two separate bus cycles: a fetch that reads the source, then a deposit that writes the fetched byte to the destination. Memory-to-memory, memory-to-I/O, I/O-to-memory and I/O-to-I/O moves are all possible.

A channel is loaded through a one-cycle configuration strobe. Its trigger source is chosen at load time: a level request pin from outside the chip (resynchronised internally), a one-cycle strobe from an on-chip timer or serial unit, or a software start that runs the whole block. The engine asks for the bus with a request/grant pair, runs ready-terminated bus cycles, and pulses a per-channel interrupt when the count runs out.

Top module: `byte_dma_pair`

## Requirements
- R1: Every transfer is a read cycle at the source pointer followed by a write cycle at the destination pointer, and the write carries exactly the byte returned by the read.
- R2: With grant held and ready given in the first waiting cycle, the fetch cycles of back-to-back transfers complete exactly 8 clocks apart, and never closer.
- R3: `bus_io_o` is high during a fetch when the source pointer selects I/O space and during a deposit when the destination pointer selects I/O space, low for memory space.
- R4: After each deposit a pointer steps by its step code: 2'b00 hold, 2'b01 add one, 2'b10 subtract one (2'b11 holds).
- R5: The count drops by one per deposit; the deposit that takes it to zero clears the channel's enable and raises that channel's interrupt for exactly one clock two clocks after the deposit handshake.
- R6: Trigger code 2'b00 (external): the request pin passes through two flops, so `bus_req_o` is still low two clocks after the pin rises and high on the third; transfers continue while the pin stays high.
- R7: Trigger code 2'b01 (internal strobe): each one-cycle strobe yields exactly one transfer.
- R8: Trigger code 2'b10 (software): a start pulse on an enabled channel runs transfers back to back until the count ends.
- R9: When both channels request, channel 0 wins; arbitration occurs only between complete transfers, so channel 1 waits while channel 0 keeps requesting.
- R10: While `bus_ready_i` is low in a bus cycle, the cycle is held with address, direction and space unchanged.
- R11: `bus_req_o` is held from arbitration to the end of the deposit; no bus cycle starts until `bus_gnt_i` is high.
- R12: A channel loaded with a count of zero stays disabled: a start pulse leaves `bus_req_o` low and no bus cycle occurs.
- R13: Under reset `bus_req_o`, `bus_cyc_o` and every interrupt output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for the channel picked by cfg_ch_i |
| cfg_ch_i | input | CHW | Channel being loaded |
| cfg_src_i | input | AW | Source pointer start value |
| cfg_src_io_i | input | 1 | Source in I/O space (1) or memory (0) |
| cfg_src_step_i | input | 2 | Source step code |
| cfg_dst_i | input | AW | Destination pointer start value |
| cfg_dst_io_i | input | 1 | Destination in I/O space (1) or memory (0) |
| cfg_dst_step_i | input | 2 | Destination step code |
| cfg_cnt_i | input | CW | Number of bytes to move |
| cfg_trig_i | input | 2 | Trigger source code |
| cfg_en_i | input | 1 | Enable the channel |
| ext_req_i | input | NCH | Asynchronous external request pins |
| int_stb_i | input | NCH | On-chip request strobes |
| sw_start_i | input | NCH | Software start pulses |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cyc_o | output | 1 | Bus cycle waiting for ready |
| bus_write_o | output | 1 | Deposit (1) or fetch (0) |
| bus_io_o | output | 1 | I/O space (1) or memory (0) |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Byte written in a deposit |
| bus_rdata_i | input | 8 | Byte returned in a fetch |
| bus_ready_i | input | 1 | Ends the current bus cycle |
| irq_o | output | NCH | Per-channel end-of-count pulse |

## Verification
Every cycle, the assertions watch the bus protocol: a deposit only after an unmatched fetch, fetches no closer than 8 clocks, a stalled cycle holding its address and direction, bus cycles only inside a request tenure, and interrupts as single-clock pulses that trail a deposit by two clocks. The scenarios show what depends on channel state and trigger source: the byte values and addresses produced by each step code and space select, the two-flop delay on the external pin, one transfer per internal strobe, channel 0 priority, the grant stall, and a zero count that never starts.

// File: rtl/byte_dma_pkg.sv
package byte_dma_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSVD = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    TRIG_EXT = 2'b00,
    TRIG_INT = 2'b01,
    TRIG_SW  = 2'b10,
    TRIG_OFF = 2'b11
  } trig_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_F_SET,
    ST_F_WAIT,
    ST_F_END,
    ST_D_SET,
    ST_D_WAIT,
    ST_D_END
  } xfer_st_e;

endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import byte_dma_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic          cfg_src_io_i,
  input  logic [1:0]    cfg_src_step_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic          cfg_dst_io_i,
  input  logic [1:0]    cfg_dst_step_i,
  input  logic [CW-1:0] cfg_cnt_i,
  input  logic [1:0]    cfg_trig_i,
  input  logic          cfg_en_i,
  input  logic          ext_req_i,
  input  logic          int_stb_i,
  input  logic          sw_start_i,
  input  logic          start_i,
  input  logic          done_i,
  output logic          req_o,
  output logic [AW-1:0] src_o,
  output logic          src_io_o,
  output logic [AW-1:0] dst_o,
  output logic          dst_io_o,
  output logic          irq_o
);
  logic [AW-1:0] src_q, dst_q;
  logic          src_io_q, dst_io_q;
  step_e         src_step_q, dst_step_q;
  trig_e         trig_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, pend_q, go_q, irq_q;
  logic          last;

  function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] p, step_e s);
    case (s)
      STEP_INC: step_ptr = p + AW'(1);
      STEP_DEC: step_ptr = p - AW'(1);
      default:  step_ptr = p;
    endcase
  endfunction

  assign last = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= '0;
      dst_q      <= '0;
      src_io_q   <= 1'b0;
      dst_io_q   <= 1'b0;
      src_step_q <= STEP_HOLD;
      dst_step_q <= STEP_HOLD;
      trig_q     <= TRIG_OFF;
      cnt_q      <= '0;
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      go_q       <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_we_i) begin
        src_q      <= cfg_src_i;
        dst_q      <= cfg_dst_i;
        src_io_q   <= cfg_src_io_i;
        dst_io_q   <= cfg_dst_io_i;
        src_step_q <= step_e'(cfg_src_step_i);
        dst_step_q <= step_e'(cfg_dst_step_i);
        trig_q     <= trig_e'(cfg_trig_i);
        cnt_q      <= cfg_cnt_i;
        en_q       <= cfg_en_i && (cfg_cnt_i != '0);
        pend_q     <= 1'b0;
        go_q       <= 1'b0;
      end else begin
        if (done_i) begin
          src_q <= step_ptr(src_q, src_step_q);
          dst_q <= step_ptr(dst_q, dst_step_q);
          cnt_q <= cnt_q - CW'(1);
          if (last) begin
            en_q  <= 1'b0;
            irq_q <= 1'b1;
          end
        end
        // a strobe arriving with the grant re-arms the channel
        if (int_stb_i && trig_q == TRIG_INT) pend_q <= 1'b1;
        else if (start_i)                    pend_q <= 1'b0;
        if (done_i && last)          go_q <= 1'b0;
        else if (sw_start_i && en_q) go_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (trig_q)
      TRIG_EXT: req_o = en_q && ext_req_i;
      TRIG_INT: req_o = en_q && pend_q;
      TRIG_SW:  req_o = en_q && go_q;
      default:  req_o = 1'b0;
    endcase
  end

  assign src_o    = src_q;
  assign src_io_o = src_io_q;
  assign dst_o    = dst_q;
  assign dst_io_o = dst_io_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import byte_dma_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned NCH = 2,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCH-1:0]          req_i,
  input  logic [NCH-1:0][AW-1:0]  src_i,
  input  logic [NCH-1:0]          src_io_i,
  input  logic [NCH-1:0][AW-1:0]  dst_i,
  input  logic [NCH-1:0]          dst_io_i,
  output logic [NCH-1:0]          start_o,
  output logic [NCH-1:0]          done_o,
  output logic                    bus_req_o,
  input  logic                    bus_gnt_i,
  output logic                    bus_cyc_o,
  output logic                    bus_write_o,
  output logic                    bus_io_o,
  output logic [AW-1:0]           bus_addr_o,
  output logic [7:0]              bus_wdata_o,
  input  logic [7:0]              bus_rdata_i,
  input  logic                    bus_ready_i
);
  xfer_st_e       state_q, state_d;
  logic [CHW-1:0] ch_q, pick;
  logic [7:0]     data_q;
  logic           any_req, fetch_ph, dep_ph;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) pick = CHW'(i);
    end
  end

  assign any_req = |req_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (any_req) state_d = ST_GRANT;
      ST_GRANT:  if (bus_gnt_i) state_d = ST_F_SET;
      ST_F_SET:  state_d = ST_F_WAIT;
      ST_F_WAIT: if (bus_ready_i) state_d = ST_F_END;
      ST_F_END:  state_d = ST_D_SET;
      ST_D_SET:  state_d = ST_D_WAIT;
      ST_D_WAIT: if (bus_ready_i) state_d = ST_D_END;
      ST_D_END:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && any_req) ch_q <= pick;
      if (state_q == ST_F_WAIT && bus_ready_i) data_q <= bus_rdata_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      start_o[i] = (state_q == ST_IDLE) && any_req && (pick == CHW'(i));
      done_o[i]  = (state_q == ST_D_END) && (ch_q == CHW'(i));
    end
  end

  assign fetch_ph = (state_q == ST_F_SET) || (state_q == ST_F_WAIT) || (state_q == ST_F_END);
  assign dep_ph   = (state_q == ST_D_SET) || (state_q == ST_D_WAIT) || (state_q == ST_D_END);

  assign bus_req_o   = (state_q != ST_IDLE);
  assign bus_cyc_o   = (state_q == ST_F_WAIT) || (state_q == ST_D_WAIT);
  assign bus_write_o = dep_ph;
  assign bus_io_o    = fetch_ph ? src_io_i[ch_q] : (dep_ph ? dst_io_i[ch_q] : 1'b0);
  assign bus_addr_o  = fetch_ph ? src_i[ch_q] : (dep_ph ? dst_i[ch_q] : '0);
  assign bus_wdata_o = data_q;
endmodule

// File: rtl/byte_dma_pair.sv
module byte_dma_pair
  import byte_dma_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 2,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [AW-1:0]  cfg_src_i,
  input  logic           cfg_src_io_i,
  input  logic [1:0]     cfg_src_step_i,
  input  logic [AW-1:0]  cfg_dst_i,
  input  logic           cfg_dst_io_i,
  input  logic [1:0]     cfg_dst_step_i,
  input  logic [CW-1:0]  cfg_cnt_i,
  input  logic [1:0]     cfg_trig_i,
  input  logic           cfg_en_i,
  input  logic [NCH-1:0] ext_req_i,
  input  logic [NCH-1:0] int_stb_i,
  input  logic [NCH-1:0] sw_start_i,
  output logic           bus_req_o,
  input  logic           bus_gnt_i,
  output logic           bus_cyc_o,
  output logic           bus_write_o,
  output logic           bus_io_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [7:0]     bus_wdata_o,
  input  logic [7:0]     bus_rdata_i,
  input  logic           bus_ready_i,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0]         ext_sync, req_w, start_w, done_w, src_io_w, dst_io_w;
  logic [NCH-1:0][AW-1:0] src_w, dst_w;

  dma_sync #(.W(NCH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_req_i),
    .q_o   (ext_sync)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan #(.AW(AW), .CW(CW)) i_chan (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cfg_we_i      (cfg_we_i && (cfg_ch_i == CHW'(g))),
      .cfg_src_i     (cfg_src_i),
      .cfg_src_io_i  (cfg_src_io_i),
      .cfg_src_step_i(cfg_src_step_i),
      .cfg_dst_i     (cfg_dst_i),
      .cfg_dst_io_i  (cfg_dst_io_i),
      .cfg_dst_step_i(cfg_dst_step_i),
      .cfg_cnt_i     (cfg_cnt_i),
      .cfg_trig_i    (cfg_trig_i),
      .cfg_en_i      (cfg_en_i),
      .ext_req_i     (ext_sync[g]),
      .int_stb_i     (int_stb_i[g]),
      .sw_start_i    (sw_start_i[g]),
      .start_i       (start_w[g]),
      .done_i        (done_w[g]),
      .req_o         (req_w[g]),
      .src_o         (src_w[g]),
      .src_io_o      (src_io_w[g]),
      .dst_o         (dst_w[g]),
      .dst_io_o      (dst_io_w[g]),
      .irq_o         (irq_o[g])
    );
  end

  dma_engine #(.AW(AW), .NCH(NCH)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_w),
    .src_i      (src_w),
    .src_io_i   (src_io_w),
    .dst_i      (dst_w),
    .dst_io_i   (dst_io_w),
    .start_o    (start_w),
    .done_o     (done_w),
    .bus_req_o  (bus_req_o),
    .bus_gnt_i  (bus_gnt_i),
    .bus_cyc_o  (bus_cyc_o),
    .bus_write_o(bus_write_o),
    .bus_io_o   (bus_io_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i),
    .bus_ready_i(bus_ready_i)
  );
endmodule

// File: rtl/byte_dma_pair_chk.sv
module byte_dma_pair_chk #(
  parameter int unsigned AW  = 20,
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bus_req_o,
  input logic           bus_cyc_o,
  input logic           bus_write_o,
  input logic           bus_io_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic           bus_ready_i,
  input logic [NCH-1:0] irq_o
);
  logic       rd_pend_q, seen_q;
  logic [3:0] gap_q;
  logic       rd_done, wr_done;

  assign rd_done = bus_cyc_o && bus_ready_i && !bus_write_o;
  assign wr_done = bus_cyc_o && bus_ready_i && bus_write_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      seen_q    <= 1'b0;
      gap_q     <= '0;
    end else begin
      if (rd_done) rd_pend_q <= 1'b1;
      else if (wr_done) rd_pend_q <= 1'b0;
      if (rd_done) begin
        seen_q <= 1'b1;
        gap_q  <= 4'd1;
      end else if (gap_q != 4'hF) begin
        gap_q <= gap_q + 4'd1;
      end
    end
  end

  a_r1_deposit_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |-> rd_pend_q);
  a_r1_no_double_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |-> !rd_pend_q);
  a_r2_fetch_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done && seen_q) |-> (gap_q >= 4'd8));
  a_r10_hold_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !bus_ready_i) |=> (bus_cyc_o && $stable(bus_addr_o)
                                     && $stable(bus_write_o) && $stable(bus_io_o)));
  a_r11_cycle_in_tenure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> bus_req_o);
  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |=> (irq_o == '0));
  a_r5_irq_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  a_r5_irq_after_deposit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> $past(wr_done, 2));
endmodule

bind byte_dma_pair byte_dma_pair_chk #(.AW(AW), .NCH(NCH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_o  (bus_req_o),
  .bus_cyc_o  (bus_cyc_o),
  .bus_write_o(bus_write_o),
  .bus_io_o   (bus_io_o),
  .bus_addr_o (bus_addr_o),
  .bus_ready_i(bus_ready_i),
  .irq_o      (irq_o)
);

// File: tb/test_byte_dma_pair.sv
module test_byte_dma_pair;
  localparam int AW  = 20;
  localparam int CW  = 16;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [0:0]     cfg_ch = '0;
  logic [AW-1:0]  cfg_src = '0, cfg_dst = '0;
  logic           cfg_src_io = 1'b0, cfg_dst_io = 1'b0;
  logic [1:0]     cfg_src_step = '0, cfg_dst_step = '0, cfg_trig = '0;
  logic [CW-1:0]  cfg_cnt = '0;
  logic           cfg_en = 1'b0;
  logic [NCH-1:0] ext_req = '0, int_stb = '0, sw_start = '0;
  logic           bus_req, bus_cyc, bus_write, bus_io;
  logic           bus_gnt = 1'b1;
  logic           bus_ready = 1'b0;
  logic [AW-1:0]  bus_addr;
  logic [7:0]     bus_wdata, bus_rdata;
  logic [NCH-1:0] irq;

  typedef struct packed {
    logic          wr;
    logic          io;
    logic [AW-1:0] addr;
    logic [7:0]    data;
  } item_t;

  item_t exp_q[$];
  int    checks = 0, fails = 0, cyc_n = 0, ws = 0;
  int    wcnt = 0, last_rd = -1, min_gap = 1000;
  int    irq_cnt[NCH];
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #4ns clk = ~clk;

  byte_dma_pair #(.AW(AW), .CW(CW), .NCH(NCH)) i_byte_dma_pair (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_src_i(cfg_src), .cfg_src_io_i(cfg_src_io), .cfg_src_step_i(cfg_src_step),
    .cfg_dst_i(cfg_dst), .cfg_dst_io_i(cfg_dst_io), .cfg_dst_step_i(cfg_dst_step),
    .cfg_cnt_i(cfg_cnt), .cfg_trig_i(cfg_trig), .cfg_en_i(cfg_en),
    .ext_req_i(ext_req), .int_stb_i(int_stb), .sw_start_i(sw_start),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cyc_o(bus_cyc),
    .bus_write_o(bus_write), .bus_io_o(bus_io), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready),
    .irq_o(irq)
  );

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a, logic io);
    return a[7:0] ^ a[15:8] ^ (io ? 8'hC3 : 8'h3C);
  endfunction

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, int st);
    if (st == 1) return a + 1'b1;
    if (st == 2) return a - 1'b1;
    return a;
  endfunction

  assign bus_rdata = mem_byte(bus_addr, bus_io);

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor, ready driver and interrupt counter
  always @(negedge clk) begin
    cyc_n++;
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) if (irq[i]) irq_cnt[i]++;
      if (bus_cyc) begin
        if (wcnt >= ws) begin
          item_t got;
          bus_ready = 1'b1;
          wcnt = 0;
          got.wr   = bus_write;
          got.io   = bus_io;
          got.addr = bus_addr;
          got.data = bus_write ? bus_wdata : bus_rdata;
          if (exp_q.size() == 0) begin
            check(1'b0, cur_req, "unexpected bus cycle", int'(got), 0);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            check(got == e, cur_req, "bus cycle wr/io/addr/data", int'(got), int'(e));
          end
          if (!got.wr) begin
            if (last_rd >= 0 && (cyc_n - last_rd) < min_gap) min_gap = cyc_n - last_rd;
            last_rd = cyc_n;
          end
        end else begin
          bus_ready = 1'b0;
          wcnt++;
        end
      end else begin
        bus_ready = 1'b0;
      end
    end
  end

  task automatic cfg(int ch, int src, int sio, int sst, int dst, int dio, int dstp,
                     int cnt, int trig, int en);
    @(negedge clk);
    cfg_ch = 1'(ch); cfg_src = AW'(src); cfg_src_io = 1'(sio); cfg_src_step = 2'(sst);
    cfg_dst = AW'(dst); cfg_dst_io = 1'(dio); cfg_dst_step = 2'(dstp);
    cfg_cnt = CW'(cnt); cfg_trig = 2'(trig); cfg_en = 1'(en); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_block(int src, int sio, int sst, int dst, int dio, int dstp, int n);
    logic [AW-1:0] s, d;
    s = AW'(src); d = AW'(dst);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = mem_byte(s, 1'(sio));
      exp_q.push_back({1'b0, 1'(sio), s, b});
      exp_q.push_back({1'b1, 1'(dio), d, b});
      s = step_addr(s, sst);
      d = step_addr(d, dstp);
    end
  endtask

  task automatic pulse_sw(logic [NCH-1:0] m);
    @(negedge clk); sw_start = m;
    @(negedge clk); sw_start = '0;
  endtask

  task automatic pulse_int(logic [NCH-1:0] m);
    @(negedge clk); int_stb = m;
    @(negedge clk); int_stb = '0;
  endtask

  task automatic drain(string r);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (16) @(negedge clk);
    check(exp_q.size() == 0, r, "pending bus cycles", exp_q.size(), 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    int b0, b1;
    for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(bus_req == 1'b0, "R13", "bus_req in reset", bus_req, 0);
    check(bus_cyc == 1'b0, "R13", "bus_cyc in reset", bus_cyc, 0);
    check(irq == '0, "R13", "irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 software block, R3 space bits, R2 spacing, R5 end-of-count
    cur_req = "R8";
    b0 = irq_cnt[0];
    cfg(0, 'h00100, 0, 1, 'h00040, 1, 0, 3, 2, 1);
    expect_block('h00100, 0, 1, 'h00040, 1, 0, 3);
    last_rd = -1; min_gap = 1000;
    pulse_sw(2'b01);
    drain("R8");
    check(min_gap == 8, "R2", "fetch-to-fetch clocks", min_gap, 8);
    check(irq_cnt[0] - b0 == 1, "R5", "irq0 pulses", irq_cnt[0] - b0, 1);

    // R4 decrement, R10 wait states
    cur_req = "R4";
    ws = 2;
    b1 = irq_cnt[1];
    cfg(1, 'h02000, 1, 2, 'h00300, 0, 1, 3, 2, 1);
    expect_block('h02000, 1, 2, 'h00300, 0, 1, 3);
    pulse_sw(2'b10);
    drain("R10");
    check(irq_cnt[1] - b1 == 1, "R5", "irq1 pulses", irq_cnt[1] - b1, 1);
    ws = 0;

    // R7 one transfer per strobe
    cur_req = "R7";
    b0 = irq_cnt[0];
    cfg(0, 'h00500, 0, 1, 'h00600, 0, 1, 2, 1, 1);
    expect_block('h00500, 0, 1, 'h00600, 0, 1, 1);
    pulse_int(2'b01);
    drain("R7");
    check(irq_cnt[0] == b0, "R7", "irq0 after first strobe", irq_cnt[0] - b0, 0);
    expect_block('h00501, 0, 1, 'h00601, 0, 1, 1);
    pulse_int(2'b01);
    drain("R7");
    check(irq_cnt[0] - b0 == 1, "R5", "irq0 after last strobe", irq_cnt[0] - b0, 1);

    // R6 external pin through two flops, level sensitive
    cur_req = "R6";
    cfg(1, 'h00700, 1, 0, 'h00800, 1, 1, 5, 0, 1);
    expect_block('h00700, 1, 0, 'h00800, 1, 1, 1);
    @(negedge clk); ext_req = 2'b10;
    @(negedge clk);
    @(negedge clk);
    check(bus_req == 1'b0, "R6", "bus_req two clocks after pin", bus_req, 0);
    @(negedge clk);
    check(bus_req == 1'b1, "R6", "bus_req three clocks after pin", bus_req, 1);
    while (exp_q.size() > 1) @(negedge clk);
    ext_req = 2'b00;
    drain("R6");

    // R9 fixed priority at transfer boundaries
    cur_req = "R9";
    cfg(0, 'h00A00, 0, 1, 'h00B00, 0, 1, 2, 2, 1);
    cfg(1, 'h00C00, 0, 1, 'h00D00, 1, 1, 2, 2, 1);
    expect_block('h00A00, 0, 1, 'h00B00, 0, 1, 2);
    expect_block('h00C00, 0, 1, 'h00D00, 1, 1, 2);
    pulse_sw(2'b11);
    drain("R9");

    // R11 grant stall
    cur_req = "R11";
    bus_gnt = 1'b0;
    cfg(1, 'h00E00, 0, 0, 'h00F00, 0, 0, 1, 2, 1);
    expect_block('h00E00, 0, 0, 'h00F00, 0, 0, 1);
    pulse_sw(2'b10);
    repeat (20) @(negedge clk);
    check(bus_req == 1'b1, "R11", "bus_req while waiting grant", bus_req, 1);
    check(exp_q.size() == 2, "R11", "bus cycles before grant", 2 - exp_q.size(), 0);
    bus_gnt = 1'b1;
    drain("R11");

    // R12 zero count never starts
    cur_req = "R12";
    cfg(0, 'h01000, 0, 1, 'h01100, 0, 1, 0, 2, 1);
    pulse_sw(2'b01);
    repeat (30) @(negedge clk);
    check(bus_req == 1'b0, "R12", "bus_req after zero-count start", bus_req, 0);
    check(exp_q.size() == 0, "R12", "queue", exp_q.size(), 0);

    finished = 1'b1;
    report();
  end
endmodule